// File: doc/BRIEF.md
# IO address translation walker

This block turns the addresses that devices use for DMA into physical addresses. The translation table sits in system memory. Two 64-bit registers set up the walk: a control word and the table base. Both can be reached through a small register port, with either a full 64-bit access or a 32-bit access to one half.

For each request, the walker works out the byte address of one 8-byte table entry and fetches it through a read handshake. It then decodes the entry and returns one of two results: a physical address and the page offset mask, or a fault code.

The table index is a slice of the request address, and the slice depends on two settings. The table-size code sets how wide the slice is. The table-window mode sets where the slice starts: at bit 13 in 8K mode and at bit 16 in 64K mode. Each entry then chooses its own page size, 8K or 64K. When translation is off, addresses pass through unchanged. Only one request is handled at a time.

Top module: `iova_xlate_walker`

## Requirements
- R1: After reset, both registers read as zero and translation is off.
- R2: The enable is bit 0 of the control register. When it is clear, an accepted request does three things: it returns its own address as the physical address, it reports offset mask 0x1FFF with fault code 0, and it issues no memory read.
- R3: The control register is at byte offset 0x0 and the base register at 0x8.
  - A full access uses that offset.
  - A 32-bit access at +0 reaches bits 63:32 and one at +4 reaches bits 31:0, both carried on bits 31:0 of the data buses.
  - A 32-bit write leaves the other half unchanged.
  - A 32-bit read returns zero in bits 63:32.
- R4: With control bit 2 clear (8K mode), size code n sits in control bits 18:16 and may be 0 to 7. The entry is read from base + (address bits [22+n:13] placed so that bit 13 lands at bit 3).
- R5: With control bit 2 set (64K mode), size codes 0 to 5 read the entry at base + (address bits [25+n:16] placed so that bit 16 lands at bit 3). Codes 6 and 7 return fault code 2 and issue no memory read.
- R6: Each entry is assembled big-endian. Response byte lane k (bits 8k+7:8k) holds the byte at entry address + k, and the byte at +0 becomes entry bits 63:56.
- R7: An entry with bit 63 clear returns fault code 1, with physical address 0 and mask 0.
- R8: Entry bit 61 selects the page size.
  - When it is set, the result is entry bits [40:16] followed by request bits [15:0], with mask 0xFFFF.
  - When it is clear, the result is entry bits [40:13] followed by request bits [12:0], with mask 0x1FFF.
  - Entry bits outside the physical field are ignored.
- R9: A write request (req_write=1) to a valid entry whose bit 1 is clear returns fault code 3, with physical address 0 and mask 0. Read requests to such an entry, and write requests to an entry with bit 1 set, translate normally.
- R10: req_ready is low from the cycle after a request is accepted until its result has been presented. rsp_valid is high for exactly one cycle per request.
- R11: mem_rd_valid stays high with a stable mem_rd_addr until mem_rd_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 4 | Register byte offset |
| cfg_wen | input | 1 | Register write strobe |
| cfg_half | input | 1 | 1 = 32-bit access, 0 = 64-bit access |
| cfg_wdata | input | 64 | Register write data |
| cfg_rdata | output | 64 | Register read data (combinational) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted when both high |
| req_addr | input | 64 | Device address to translate |
| req_write | input | 1 | Request is a write access |
| mem_rd_valid | output | 1 | Entry fetch request |
| mem_rd_ready | input | 1 | Memory accepts the fetch |
| mem_rd_addr | output | 64 | Entry byte address |
| mem_rsp_valid | input | 1 | Entry data present |
| mem_rsp_data | input | 64 | Entry bytes, lane k = byte at address + k |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_paddr | output | 64 | Physical address, 0 on fault |
| rsp_mask | output | 64 | Page offset mask, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 invalid entry, 2 unsupported size, 3 write to read-only |

## Verification
The checker relies on the memory side behaving well. mem_rsp_valid is expected only while a fetch is outstanding, for one cycle after mem_rd_ready has been given. The register port is expected not to change the control word in the cycle a request is accepted.

The bench memory model answers only after it has granted a fetch, with a configurable grant delay, and it drops its response strobe after one cycle. The bench writes registers only while the walker is idle, between translations.

// File: rtl/iova_xlate_pkg.sv
package iova_xlate_pkg;
  localparam int XW       = 64;
  localparam int HW       = XW / 2;
  localparam int PA_MSB   = 40;
  localparam int SMALL_SH = 13;
  localparam int BIG_SH   = 16;
  localparam int CODE_W   = 3;
  localparam int IDX_MIN  = 10;
  localparam int ENT_SH   = 3;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_SIZE    = 2'd2,
    FLT_PERM    = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } walk_st_e;

  localparam logic [XW-1:0] ONE = XW'(1);

  // byte offset of the table entry inside the table
  function automatic logic [XW-1:0] entry_offset(input logic [XW-1:0] va,
                                                 input logic wide,
                                                 input logic [CODE_W-1:0] code);
    int unsigned lo;
    int unsigned hi;
    logic [XW-1:0] keep;
    lo   = wide ? BIG_SH : SMALL_SH;
    hi   = lo + IDX_MIN - 1 + int'(code);
    keep = ((ONE << (hi + 1)) - ONE) & ~((ONE << lo) - ONE);
    return (va & keep) >> (lo - ENT_SH);
  endfunction

  function automatic logic size_unsupported(input logic wide, input logic [CODE_W-1:0] code);
    return wide && (code > 3'd5);
  endfunction

  // lane k carries byte at address+k; lowest address is most significant
  function automatic logic [XW-1:0] be_assemble(input logic [XW-1:0] lanes);
    logic [XW-1:0] v;
    for (int k = 0; k < XW / 8; k++) v[XW-1-8*k -: 8] = lanes[8*k +: 8];
    return v;
  endfunction

  function automatic logic [XW-1:0] offset_mask(input logic big);
    return big ? ((ONE << BIG_SH) - ONE) : ((ONE << SMALL_SH) - ONE);
  endfunction
endpackage

// File: rtl/iova_cfg_regs.sv
module iova_cfg_regs
  import iova_xlate_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    cfg_addr,
  input  logic          cfg_wen,
  input  logic          cfg_half,
  input  logic [XW-1:0] cfg_wdata,
  output logic [XW-1:0] cfg_rdata,
  output logic [XW-1:0] ctrl_q,
  output logic [XW-1:0] base_q
);
  localparam int NREG = 2;

  logic acc_ok;
  logic wr_hit;
  logic [XW-1:0] sel_word;

  assign acc_ok = (cfg_addr[1:0] == 2'b00) && (cfg_half || !cfg_addr[2]);
  assign wr_hit = cfg_wen && acc_ok;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [XW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (wr_hit && (cfg_addr[3] == 1'(r))) begin
        if (!cfg_half)        word_q <= cfg_wdata;
        else if (cfg_addr[2]) word_q[HW-1:0]  <= cfg_wdata[HW-1:0];
        else                  word_q[XW-1:HW] <= cfg_wdata[HW-1:0];
      end
    end
  end

  assign ctrl_q   = g_reg[0].word_q;
  assign base_q   = g_reg[1].word_q;
  assign sel_word = cfg_addr[3] ? base_q : ctrl_q;

  always_comb begin
    if (!acc_ok)          cfg_rdata = '0;
    else if (!cfg_half)   cfg_rdata = sel_word;
    else if (cfg_addr[2]) cfg_rdata = {{HW{1'b0}}, sel_word[HW-1:0]};
    else                  cfg_rdata = {{HW{1'b0}}, sel_word[XW-1:HW]};
  end
endmodule

// File: rtl/iova_index_calc.sv
module iova_index_calc
  import iova_xlate_pkg::*;
(
  input  logic [XW-1:0]     va,
  input  logic [XW-1:0]     table_base,
  input  logic              wide,
  input  logic [CODE_W-1:0] code,
  output logic [XW-1:0]     ent_addr,
  output logic              bad_size
);
  assign ent_addr = table_base + entry_offset(va, wide, code);
  assign bad_size = size_unsupported(wide, code);
endmodule

// File: rtl/iova_entry_check.sv
module iova_entry_check
  import iova_xlate_pkg::*;
(
  input  logic [XW-1:0] lanes,
  input  logic [XW-1:0] va,
  input  logic          is_write,
  output logic [XW-1:0] paddr,
  output logic [XW-1:0] pmask,
  output fault_e        fault
);
  localparam logic [XW-1:0] PHYS_KEEP = (ONE << (PA_MSB + 1)) - ONE;

  logic [XW-1:0] ent;
  logic [XW-1:0] omask;
  logic [XW-1:0] page_base;

  assign ent       = be_assemble(lanes);
  assign omask     = offset_mask(ent[61]);
  assign page_base = ent & PHYS_KEEP & ~omask;

  always_comb begin
    if (!ent[63])                 fault = FLT_INVALID;
    else if (is_write && !ent[1]) fault = FLT_PERM;
    else                          fault = FLT_NONE;
  end

  assign paddr = (fault == FLT_NONE) ? (page_base | (va & omask)) : '0;
  assign pmask = (fault == FLT_NONE) ? omask : '0;
endmodule

// File: rtl/iova_xlate_walker.sv
module iova_xlate_walker
  import iova_xlate_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    cfg_addr,
  input  logic          cfg_wen,
  input  logic          cfg_half,
  input  logic [XW-1:0] cfg_wdata,
  output logic [XW-1:0] cfg_rdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [XW-1:0] req_addr,
  input  logic          req_write,
  output logic          mem_rd_valid,
  input  logic          mem_rd_ready,
  output logic [XW-1:0] mem_rd_addr,
  input  logic          mem_rsp_valid,
  input  logic [XW-1:0] mem_rsp_data,
  output logic          rsp_valid,
  output logic [XW-1:0] rsp_paddr,
  output logic [XW-1:0] rsp_mask,
  output logic [1:0]    rsp_fault
);
  localparam logic [XW-1:0] PASS_MASK = (ONE << SMALL_SH) - ONE;

  logic [XW-1:0] ctrl_q, base_q;
  logic          xlate_on, wide_mode;
  logic [CODE_W-1:0] size_code;
  logic          req_fire;
  logic [XW-1:0] calc_addr;
  logic          calc_bad;
  logic [XW-1:0] chk_paddr, chk_mask;
  fault_e        chk_fault;

  walk_st_e      st_q;
  logic [XW-1:0] va_q, ent_addr_q, paddr_q, mask_q;
  logic          wr_q;
  fault_e        fault_q;

  iova_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wen(cfg_wen),
    .cfg_half(cfg_half), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ctrl_q(ctrl_q), .base_q(base_q)
  );

  assign xlate_on  = ctrl_q[0];
  assign wide_mode = ctrl_q[2];
  assign size_code = ctrl_q[18:16];
  assign req_ready = (st_q == ST_IDLE);
  assign req_fire  = req_valid && req_ready;

  iova_index_calc u_idx (
    .va(req_addr), .table_base(base_q), .wide(wide_mode), .code(size_code),
    .ent_addr(calc_addr), .bad_size(calc_bad)
  );

  iova_entry_check u_ent (
    .lanes(mem_rsp_data), .va(va_q), .is_write(wr_q),
    .paddr(chk_paddr), .pmask(chk_mask), .fault(chk_fault)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      va_q       <= '0;
      wr_q       <= 1'b0;
      ent_addr_q <= '0;
      paddr_q    <= '0;
      mask_q     <= '0;
      fault_q    <= FLT_NONE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_fire) begin
          va_q       <= req_addr;
          wr_q       <= req_write;
          ent_addr_q <= calc_addr;
          if (!xlate_on) begin
            paddr_q <= req_addr;
            mask_q  <= PASS_MASK;
            fault_q <= FLT_NONE;
            st_q    <= ST_RESP;
          end else if (calc_bad) begin
            paddr_q <= '0;
            mask_q  <= '0;
            fault_q <= FLT_SIZE;
            st_q    <= ST_RESP;
          end else begin
            st_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (mem_rd_ready) st_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          paddr_q <= chk_paddr;
          mask_q  <= chk_mask;
          fault_q <= chk_fault;
          st_q    <= ST_RESP;
        end
        ST_RESP: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_rd_valid = (st_q == ST_ISSUE);
  assign mem_rd_addr  = ent_addr_q;
  assign rsp_valid    = (st_q == ST_RESP);
  assign rsp_paddr    = paddr_q;
  assign rsp_mask     = mask_q;
  assign rsp_fault    = fault_q;
endmodule

// File: rtl/iova_xlate_chk.sv
module iova_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic [63:0] req_addr,
  input logic        mem_rd_valid,
  input logic        mem_rd_ready,
  input logic [63:0] mem_rd_addr,
  input logic        rsp_valid,
  input logic [63:0] rsp_paddr,
  input logic [63:0] rsp_mask,
  input logic [1:0]  rsp_fault,
  input logic        req_fire,
  input logic        xlate_on,
  input logic        wide_mode,
  input logic [2:0]  size_code
);
  // R2
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && !xlate_on |=> rsp_valid && rsp_paddr == $past(req_addr)
      && rsp_mask == 64'h1FFF && rsp_fault == 2'd0);

  // R5
  size_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && xlate_on && wide_mode && size_code >= 3'd6 |=> rsp_valid && rsp_fault == 2'd2);

  // R10
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R10
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid || rsp_valid) |-> !req_ready);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  // R7 R9
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != 2'd0 |-> rsp_paddr == 64'd0 && rsp_mask == 64'd0);
endmodule

bind iova_xlate_walker iova_xlate_chk u_chk (.*);

// File: tb/iova_xlate_walker_tb.sv
module iova_xlate_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic        cfg_wen = 1'b0;
  logic        cfg_half = 1'b0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [63:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic [63:0] rsp_paddr, rsp_mask;
  logic [1:0]  rsp_fault;

  int n_checks = 0;
  int n_fail = 0;
  int fetch_cnt = 0;
  int hold_bad = 0;
  int mem_gap = 0;
  logic [63:0] last_fetch = '0;
  logic [63:0] ent_store [logic [63:0]];

  localparam logic [63:0] BASE = 64'h0000_0000_0100_0000;

  always #2.5 clk = ~clk;

  iova_xlate_walker u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] to_lanes(input logic [63:0] v);
    logic [63:0] l;
    for (int k = 0; k < 8; k++) l[8*k +: 8] = v[63-8*k -: 8];
    return l;
  endfunction

  function automatic logic [63:0] off8(input logic [63:0] va, input int n);
    return ((va >> 13) & ((64'd1 << (10 + n)) - 1)) << 3;
  endfunction

  function automatic logic [63:0] off64(input logic [63:0] va, input int n);
    return ((va >> 16) & ((64'd1 << (10 + n)) - 1)) << 3;
  endfunction

  function automatic logic [63:0] exp_pa(input logic [63:0] e, input logic [63:0] va);
    if (e[61]) return (((e >> 16) & ((64'd1 << 25) - 1)) << 16) | {48'd0, va[15:0]};
    return (((e >> 13) & ((64'd1 << 28) - 1)) << 13) | {51'd0, va[12:0]};
  endfunction

  // memory model
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rd_valid) begin
        logic [63:0] a0;
        a0 = mem_rd_addr;
        for (int g = 0; g < mem_gap; g++) begin
          @(negedge clk);
          if (!mem_rd_valid || mem_rd_addr != a0) hold_bad++;
        end
        last_fetch = a0;
        fetch_cnt++;
        mem_rd_ready = 1'b1;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        mem_rsp_valid = 1'b1;
        mem_rsp_data = to_lanes(ent_store.exists(a0) ? ent_store[a0] : 64'd0);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic reg_wr(input logic [3:0] a, input bit half, input logic [63:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_half = half; cfg_wdata = d; cfg_wen = 1'b1;
    @(negedge clk);
    cfg_wen = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, input bit half, output logic [63:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_half = half;
    #1 d = cfg_rdata;
  endtask

  int busy_bad;
  int pulse_bad;

  task automatic xlate(input logic [63:0] va, input bit wr,
                       output logic [63:0] pa, output logic [63:0] mk, output logic [1:0] fc);
    int guard;
    busy_bad = 0; pulse_bad = 0; guard = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && guard < 200) begin
      if (req_ready) busy_bad++;
      @(negedge clk);
      guard++;
    end
    if (req_ready) busy_bad++;
    pa = rsp_paddr; mk = rsp_mask; fc = rsp_fault;
    @(negedge clk);
    if (rsp_valid) pulse_bad++;
  endtask

  task automatic walk_ok(input logic [63:0] va, input bit wr, input logic [63:0] e,
                         input logic [63:0] ent_addr, input string tag);
    logic [63:0] pa, mk;
    logic [1:0] fc;
    ent_store[ent_addr] = e;
    xlate(va, wr, pa, mk, fc);
    chk(last_fetch == ent_addr, {tag, " entry address"}, last_fetch, ent_addr);
    chk(pa == exp_pa(e, va), {tag, " physical address"}, pa, exp_pa(e, va));
    chk(mk == (e[61] ? 64'hFFFF : 64'h1FFF), {tag, " mask"}, mk, e[61] ? 64'hFFFF : 64'h1FFF);
    chk(fc == 2'd0, {tag, " fault"}, {62'd0, fc}, 64'd0);
  endtask

  task automatic t_reset();
    logic [63:0] d;
    reg_rd(4'h0, 1'b0, d);
    chk(d == 0, "R1 control after reset", d, 0);
    reg_rd(4'h8, 1'b0, d);
    chk(d == 0, "R1 base after reset", d, 0);
  endtask

  task automatic t_passthru();
    logic [63:0] pa, mk;
    logic [1:0] fc;
    int f0;
    f0 = fetch_cnt;
    xlate(64'hDEAD_BEEF_0123_4567, 1'b1, pa, mk, fc);
    chk(pa == 64'hDEAD_BEEF_0123_4567, "R1 R2 passthrough address", pa, 64'hDEAD_BEEF_0123_4567);
    chk(mk == 64'h1FFF, "R2 passthrough mask", mk, 64'h1FFF);
    chk(fc == 0, "R2 passthrough fault", {62'd0, fc}, 0);
    chk(fetch_cnt == f0, "R2 no fetch", 64'(fetch_cnt), 64'(f0));
  endtask

  task automatic t_halves();
    logic [63:0] d;
    reg_wr(4'h8, 1'b0, 64'h1111_2222_3333_4444);
    reg_wr(4'h8, 1'b1, 64'h0000_0000_AAAA_BBBB);
    reg_rd(4'h8, 1'b0, d);
    chk(d == 64'hAAAA_BBBB_3333_4444, "R3 upper half write", d, 64'hAAAA_BBBB_3333_4444);
    reg_wr(4'hC, 1'b1, 64'h0000_0000_CCCC_DDDD);
    reg_rd(4'h8, 1'b0, d);
    chk(d == 64'hAAAA_BBBB_CCCC_DDDD, "R3 lower half write", d, 64'hAAAA_BBBB_CCCC_DDDD);
    reg_rd(4'hC, 1'b1, d);
    chk(d == 64'h0000_0000_CCCC_DDDD, "R3 lower half read", d, 64'h0000_0000_CCCC_DDDD);
    reg_rd(4'h8, 1'b1, d);
    chk(d == 64'h0000_0000_AAAA_BBBB, "R3 upper half read", d, 64'h0000_0000_AAAA_BBBB);
    reg_wr(4'h0, 1'b1, 64'h0000_0000_0000_0007);
    reg_rd(4'h0, 1'b0, d);
    chk(d == 64'h0000_0007_0000_0000, "R3 control upper half", d, 64'h0000_0007_0000_0000);
    reg_wr(4'h0, 1'b0, 64'd0);
    reg_wr(4'h8, 1'b0, BASE);
  endtask

  task automatic t_8k();
    logic [63:0] va, e;
    reg_wr(4'h0, 1'b0, 64'h1);
    va = 64'h0000_0000_0012_3456;
    e  = 64'h8000_0000_ABCD_FFFE;   // small page, junk in low bits
    walk_ok(va, 1'b0, e, BASE + off8(va, 0), "R4 R6 R8 8K code0");
    va = 64'hFFFF_FFFF_FFFF_E000;
    walk_ok(va, 1'b1, 64'h8000_0000_0000_2002, BASE + off8(va, 0), "R4 8K code0 high bits");
    reg_wr(4'h0, 1'b0, 64'h0000_0000_0007_0001);
    va = 64'h0000_0000_2BCD_E123;
    walk_ok(va, 1'b0, 64'h8000_01F0_0000_6000, BASE + off8(va, 7), "R4 R8 8K code7");
  endtask

  task automatic t_64k();
    logic [63:0] va;
    reg_wr(4'h0, 1'b0, 64'h0000_0000_0002_0005);
    va = 64'h1234_5678_9ABC_DEF0;
    walk_ok(va, 1'b1, 64'hA000_0001_2345_E002, BASE + off64(va, 2), "R5 R8 64K code2");
    reg_wr(4'h0, 1'b0, 64'h0000_0000_0005_0005);
    va = 64'h0000_0000_7FFF_0010;
    walk_ok(va, 1'b0, 64'h8000_0000_4444_0000, BASE + off64(va, 5), "R5 R8 64K code5 small page");
  endtask

  task automatic t_size_bad();
    logic [63:0] pa, mk;
    logic [1:0] fc;
    int f0;
    for (int c = 6; c < 8; c++) begin
      reg_wr(4'h0, 1'b0, (64'(c) << 16) | 64'h5);
      f0 = fetch_cnt;
      xlate(64'h0000_0000_1234_0000, 1'b0, pa, mk, fc);
      chk(fc == 2'd2, "R5 unsupported size fault", {62'd0, fc}, 2);
      chk(fetch_cnt == f0, "R5 unsupported size no fetch", 64'(fetch_cnt), 64'(f0));
    end
  endtask

  task automatic t_invalid();
    logic [63:0] pa, mk, va;
    logic [1:0] fc;
    reg_wr(4'h0, 1'b0, 64'h1);
    va = 64'h0000_0000_0040_2000;
    ent_store[BASE + off8(va, 0)] = 64'h7FFF_FFFF_FFFF_FFFF;
    xlate(va, 1'b0, pa, mk, fc);
    chk(fc == 2'd1, "R7 invalid entry fault", {62'd0, fc}, 1);
    chk(pa == 0 && mk == 0, "R7 invalid entry zero result", pa | mk, 0);
  endtask

  task automatic t_perm();
    logic [63:0] pa, mk, va, e;
    logic [1:0] fc;
    reg_wr(4'h0, 1'b0, 64'h1);
    va = 64'h0000_0000_0060_4321;
    e  = 64'h8000_0000_0088_8000;
    ent_store[BASE + off8(va, 0)] = e;
    xlate(va, 1'b1, pa, mk, fc);
    chk(fc == 2'd3, "R9 write to read-only fault", {62'd0, fc}, 3);
    chk(pa == 0, "R9 write to read-only address", pa, 0);
    walk_ok(va, 1'b0, e, BASE + off8(va, 0), "R9 read of read-only page");
  endtask

  task automatic t_handshake();
    logic [63:0] va;
    mem_gap = 3;
    hold_bad = 0;
    reg_wr(4'h0, 1'b0, 64'h1);
    va = 64'h0000_0000_0071_0000;
    walk_ok(va, 1'b0, 64'h8000_0000_0100_0002, BASE + off8(va, 0), "R11 delayed grant");
    chk(hold_bad == 0, "R11 request held stable", 64'(hold_bad), 0);
    chk(busy_bad == 0, "R10 ready low while busy", 64'(busy_bad), 0);
    chk(pulse_bad == 0, "R10 one-cycle result", 64'(pulse_bad), 0);
    mem_gap = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog expired act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_passthru();
    t_halves();
    t_8k();
    t_64k();
    t_size_bad();
    t_invalid();
    t_perm();
    t_handshake();
    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule